// File: doc/BRIEF.md
# Microcode Patch Redirect Unit

This block sits between the sequencer's next-address logic and its triad store. A triad is a fixed bundle of three microinstructions, and it is the smallest unit that can be fetched or replaced. The block holds eight match entries. Each entry pairs a ROM triad address with a target slot in a writable patch RAM. The patch RAM is mapped into the address space immediately after the last ROM triad. When a fetch for a complex (vector-path) instruction presents an address that equals a live match entry, the fetch is steered into the patch RAM. The patched triad then executes in place of the ROM original. Fetches for fast (direct-path) instructions never consult the match entries.

Software, or an update loader, fills the patch RAM and the match entries through a single write port. Nothing survives a reset: every match entry comes back empty, so the patches must be loaded again. The redirect decision and the resulting address are combinational in the fetch cycle. The triad itself comes out of a registered stage one cycle later.

The fetch side uses a valid/ready handshake, and so does the triad output. A fetch is accepted when `fetch_valid` and `fetch_ready` are both high at a rising edge. `fetch_ready` is high whenever the output stage is empty or is being drained in that cycle. While `out_valid` is high and `out_ready` is low, the output triad stays frozen and no new fetch is accepted. The write port is a plain strobe with no handshake.

Top module: `mcode_patch_redirect`

## Requirements
- R1: After reset, every match entry is empty, `out_valid` is 0 and `wr_err` is 0. Patch RAM contents are not cleared by reset.
- R2: When `fetch_vec` is 1 and `fetch_addr` is below the ROM size and equal to the address of a live match entry, `redir_hit` is 1 and `redir_addr` equals ROM size plus that entry's target slot, in the same cycle.
- R3: When `fetch_vec` is 0, `redir_hit` is 0 and `redir_addr` equals `fetch_addr`, whatever the match entries hold.
- R4: When several live entries hold the same address, the entry with the lowest index supplies the target.
- R5: A `fetch_addr` at or above the ROM size (64) skips the match lookup: `redir_hit` is 0, `redir_addr` equals `fetch_addr`, and the triad is read from patch RAM slot `fetch_addr - 64`.
- R6: One cycle after a fetch is accepted, `out_valid` is 1 and `out_data` holds the triad at `redir_addr`. For ROM triad a, microinstruction k (k = 0..2, held in bits 16k+15..16k) equals 0xC000 + 3a + k.
- R7: A write with `wr_sel` = 0 and `wr_index` of 8 or above changes no match entry, and it sets `wr_err` to 1 for exactly the following cycle.
- R8: A write with `wr_sel` = 0 and `wr_index` below 8 makes that entry live, holding `wr_rom_addr` and `wr_target`. This takes effect on the next fetch cycle.
- R9: A write with `wr_sel` = 1 stores `wr_data` in patch RAM slot `wr_index`, and a later fetch of address 64 + slot returns it.
- R10: `fetch_ready` equals `!out_valid || out_ready`. While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_valid` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | 0 = match entry, 1 = patch RAM slot |
| wr_index | input | 6 | Match entry index or RAM slot |
| wr_rom_addr | input | 6 | ROM triad address to match |
| wr_target | input | 6 | Patch RAM slot to jump to |
| wr_data | input | 48 | Triad to store in patch RAM |
| wr_err | output | 1 | One-cycle pulse after a match write with a bad index |
| fetch_valid | input | 1 | Fetch request present |
| fetch_ready | output | 1 | Fetch can be accepted |
| fetch_vec | input | 1 | 1 = vector-path fetch, 0 = direct-path fetch |
| fetch_addr | input | 7 | Triad address to fetch |
| redir_hit | output | 1 | Fetch redirected into patch RAM |
| redir_addr | output | 7 | Effective triad address |
| out_valid | output | 1 | Output triad valid |
| out_ready | input | 1 | Consumer takes the triad |
| out_data | output | 48 | Fetched triad |

## Verification
The assertions take the inputs to follow the handshake: a fetch is counted only when valid and ready coincide, and the consumer may stall for any number of cycles. The write strobe may arrive in any cycle, including one that also carries a fetch. The bench changes inputs only at falling edges and holds each fetch request for exactly one accepted cycle. It programs match entries only in cycles that carry no fetch, so every redirect it checks sees a settled set of entries. Writes with out-of-range indices are sent on their own, and their effect is then observed through an ordinary fetch.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
  localparam int UOP_W      = 16;
  localparam int UOPS_TRIAD = 3;
  localparam int TRIAD_W    = UOP_W * UOPS_TRIAD;

  typedef enum logic {
    WSEL_MATCH = 1'b0,
    WSEL_RAM   = 1'b1
  } wsel_e;

  // Behavioural ROM image: microinstruction k of triad a = 0xC000 + 3a + k.
  function automatic logic [TRIAD_W-1:0] rom_triad(input int unsigned a);
    logic [TRIAD_W-1:0] t;
    t = '0;
    for (int k = 0; k < UOPS_TRIAD; k++) begin
      t[k*UOP_W +: UOP_W] = {4'hC, 12'(a * 3 + 32'(k))};
    end
    return t;
  endfunction
endpackage

// File: rtl/mpr_match_bank.sv
module mpr_match_bank #(
  parameter int NUM_MATCH = 8,
  parameter int ROM_AW    = 6,
  parameter int RAM_AW    = 6,
  parameter int IDX_W     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_index,
  input  logic [ROM_AW-1:0] wr_rom_addr,
  input  logic [RAM_AW-1:0] wr_target,
  input  logic              look_en,
  input  logic [ROM_AW-1:0] look_addr,
  output logic              hit,
  output logic [RAM_AW-1:0] hit_target
);
  logic                live   [NUM_MATCH];
  logic [ROM_AW-1:0]   key    [NUM_MATCH];
  logic [RAM_AW-1:0]   target [NUM_MATCH];
  logic [NUM_MATCH-1:0] hit_vec;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_MATCH; i++) begin
      if (!rst_n) begin
        live[i] <= 1'b0;
      end else if (wr_en && wr_index == IDX_W'(i)) begin
        live[i] <= 1'b1;
      end
      if (wr_en && wr_index == IDX_W'(i)) begin
        key[i]    <= wr_rom_addr;
        target[i] <= wr_target;
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_MATCH; g++) begin : g_cmp
      assign hit_vec[g] = look_en && live[g] && (key[g] == look_addr);
    end
  endgenerate

  // Lowest index wins: scan downward so the lowest hit is assigned last.
  always_comb begin
    hit        = 1'b0;
    hit_target = '0;
    for (int i = NUM_MATCH - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit        = 1'b1;
        hit_target = target[i];
      end
    end
  end
endmodule

// File: rtl/mpr_patch_ram.sv
module mpr_patch_ram #(
  parameter int DEPTH  = 64,
  parameter int AW     = 6,
  parameter int DATA_W = 48
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/mpr_rom.sv
module mpr_rom #(
  parameter int AW = 6
) (
  input  logic                         clk,
  input  logic                         re,
  input  logic [AW-1:0]                raddr,
  output logic [mpr_pkg::TRIAD_W-1:0]  rdata
);
  always_ff @(posedge clk) begin
    if (re) rdata <= mpr_pkg::rom_triad(32'(raddr));
  end
endmodule

// File: rtl/mcode_patch_redirect.sv
module mcode_patch_redirect #(
  parameter int NUM_MATCH  = 8,
  parameter int ROM_TRIADS = 64,
  parameter int RAM_TRIADS = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [5:0]   wr_index,
  input  logic [5:0]   wr_rom_addr,
  input  logic [5:0]   wr_target,
  input  logic [47:0]  wr_data,
  output logic         wr_err,
  input  logic         fetch_valid,
  output logic         fetch_ready,
  input  logic         fetch_vec,
  input  logic [6:0]   fetch_addr,
  output logic         redir_hit,
  output logic [6:0]   redir_addr,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [47:0]  out_data
);
  import mpr_pkg::*;

  localparam int ROM_AW  = $clog2(ROM_TRIADS);
  localparam int RAM_AW  = $clog2(RAM_TRIADS);
  localparam int ADDR_W  = $clog2(ROM_TRIADS + RAM_TRIADS);
  localparam int IDX_W   = 6;
  localparam logic [ADDR_W-1:0] ROM_BASE = ADDR_W'(ROM_TRIADS);

  logic              in_rom, look_en, hit;
  logic [RAM_AW-1:0] hit_target;
  logic              accept, use_ram, sel_ram_q;
  logic [RAM_AW-1:0] ram_idx;
  logic [TRIAD_W-1:0] rom_q, ram_q;
  logic              valid_q, err_q;

  assign in_rom  = fetch_addr < ROM_BASE;
  assign look_en = fetch_vec && in_rom;

  mpr_match_bank #(
    .NUM_MATCH(NUM_MATCH), .ROM_AW(ROM_AW), .RAM_AW(RAM_AW), .IDX_W(IDX_W)
  ) u_match (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en && (wr_sel == WSEL_MATCH)),
    .wr_index(wr_index), .wr_rom_addr(wr_rom_addr[ROM_AW-1:0]),
    .wr_target(wr_target[RAM_AW-1:0]),
    .look_en(look_en), .look_addr(fetch_addr[ROM_AW-1:0]),
    .hit(hit), .hit_target(hit_target)
  );

  assign redir_hit  = hit;
  assign redir_addr = hit ? (ROM_BASE + ADDR_W'(hit_target)) : fetch_addr;
  assign use_ram    = redir_addr >= ROM_BASE;
  assign ram_idx    = RAM_AW'(redir_addr - ROM_BASE);

  assign fetch_ready = !valid_q || out_ready;
  assign accept      = fetch_valid && fetch_ready;

  mpr_patch_ram #(.DEPTH(RAM_TRIADS), .AW(RAM_AW), .DATA_W(TRIAD_W)) u_ram (
    .clk(clk),
    .we(wr_en && (wr_sel == WSEL_RAM)), .waddr(wr_index[RAM_AW-1:0]),
    .wdata(wr_data),
    .re(accept && use_ram), .raddr(ram_idx), .rdata(ram_q)
  );

  mpr_rom #(.AW(ROM_AW)) u_rom (
    .clk(clk), .re(accept && !use_ram),
    .raddr(redir_addr[ROM_AW-1:0]), .rdata(rom_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      sel_ram_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      if (accept) begin
        valid_q   <= 1'b1;
        sel_ram_q <= use_ram;
      end else if (out_ready) begin
        valid_q <= 1'b0;
      end
      err_q <= wr_en && (wr_sel == WSEL_MATCH) && (wr_index >= IDX_W'(NUM_MATCH));
    end
  end

  assign out_valid = valid_q;
  assign out_data  = sel_ram_q ? ram_q : rom_q;
  assign wr_err    = err_q;
endmodule

// File: rtl/mpr_checker.sv
module mpr_checker #(
  parameter int NUM_MATCH  = 8,
  parameter int ROM_TRIADS = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        wr_sel,
  input logic [5:0]  wr_index,
  input logic        wr_err,
  input logic        fetch_valid,
  input logic        fetch_ready,
  input logic        fetch_vec,
  input logic [6:0]  fetch_addr,
  input logic        redir_hit,
  input logic [6:0]  redir_addr,
  input logic        out_valid,
  input logic        out_ready,
  input logic [47:0] out_data
);
  localparam logic [6:0] ROM_BASE = 7'(ROM_TRIADS);

  p_direct_no_redirect_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_vec |-> (!redir_hit && redir_addr == fetch_addr));

  p_high_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_addr >= ROM_BASE) |-> (!redir_hit && redir_addr == fetch_addr));

  p_hit_into_ram_r2: assert property (@(posedge clk) disable iff (!rst_n)
    redir_hit |-> (redir_addr >= ROM_BASE && fetch_addr < ROM_BASE));

  p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && wr_index >= 6'(NUM_MATCH)) |=> wr_err);

  p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !wr_sel && wr_index >= 6'(NUM_MATCH)) |=> !wr_err);

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_accept_fills_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_ready) |=> out_valid);
endmodule

bind mcode_patch_redirect mpr_checker #(
  .NUM_MATCH(NUM_MATCH), .ROM_TRIADS(ROM_TRIADS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_index(wr_index), .wr_err(wr_err), .fetch_valid(fetch_valid),
  .fetch_ready(fetch_ready), .fetch_vec(fetch_vec), .fetch_addr(fetch_addr),
  .redir_hit(redir_hit), .redir_addr(redir_addr), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data)
);

// File: tb/tb_mcode_patch_redirect.sv
`timescale 1ns/1ps
module tb_mcode_patch_redirect;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0;
  logic [5:0] wr_index = '0, wr_rom_addr = '0, wr_target = '0;
  logic [47:0] wr_data = '0;
  logic wr_err;
  logic fetch_valid = 1'b0, fetch_vec = 1'b0, out_ready = 1'b1;
  logic fetch_ready, redir_hit, out_valid;
  logic [6:0] fetch_addr = '0, redir_addr;
  logic [47:0] out_data;

  int n_checks = 0;
  int n_fail = 0;
  logic [47:0] ram_model [64];

  always #4 clk = ~clk;

  mcode_patch_redirect dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_index(wr_index), .wr_rom_addr(wr_rom_addr), .wr_target(wr_target),
    .wr_data(wr_data), .wr_err(wr_err), .fetch_valid(fetch_valid),
    .fetch_ready(fetch_ready), .fetch_vec(fetch_vec), .fetch_addr(fetch_addr),
    .redir_hit(redir_hit), .redir_addr(redir_addr), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  // {vec, addr[6:0], exp_hit, exp_redir[6:0]}
  localparam logic [15:0] TBL [0:7] = '{
    {1'b1, 7'd5,   1'b1, 7'd66},
    {1'b0, 7'd5,   1'b0, 7'd5},
    {1'b1, 7'd9,   1'b1, 7'd71},
    {1'b1, 7'd10,  1'b0, 7'd10},
    {1'b1, 7'd63,  1'b1, 7'd127},
    {1'b1, 7'd64,  1'b0, 7'd64},
    {1'b0, 7'd127, 1'b0, 7'd127},
    {1'b1, 7'd0,   1'b0, 7'd0}
  };

  function automatic logic [47:0] rom_exp(input int a);
    logic [47:0] t;
    for (int k = 0; k < 3; k++) t[k*16 +: 16] = 16'hC000 + 16'(3 * a + k);
    return t;
  endfunction

  function automatic logic [47:0] exp_triad(input logic [6:0] ra);
    if (ra < 7'd64) return rom_exp(int'(ra));
    return ram_model[ra - 7'd64];
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic write_match(input int idx, input int ra, input int tg);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; wr_index = 6'(idx);
    wr_rom_addr = 6'(ra); wr_target = 6'(tg);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic write_ram(input int idx, input logic [47:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b1; wr_index = 6'(idx); wr_data = d;
    ram_model[idx] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_fetch(input string req, input logic vec, input logic [6:0] a,
                          input logic ehit, input logic [6:0] eaddr);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_vec = vec; fetch_addr = a;
    #1;
    check(req, "redir_hit", 64'(redir_hit), 64'(ehit));
    check(req, "redir_addr", 64'(redir_addr), 64'(eaddr));
    @(negedge clk);
    fetch_valid = 1'b0;
    check(req, "out_valid", 64'(out_valid), 64'd1);
    check(req, "out_data", 64'(out_data), 64'(exp_triad(eaddr)));
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "out_valid", 64'(out_valid), 64'd0);
    check("R1", "wr_err", 64'(wr_err), 64'd0);
    rst_n = 1'b1;

    // R9: patch RAM loads
    write_ram(0,  48'hB000_B100_B200);
    write_ram(2,  48'hB002_B102_B202);
    write_ram(7,  48'hB007_B107_B207);
    write_ram(11, 48'hB00B_B10B_B20B);
    write_ram(63, 48'hB03F_B13F_B23F);
    // R8, R4: match entries, entries 3 and 5 share address 9
    write_match(0, 5, 2);
    write_match(5, 9, 11);
    write_match(3, 9, 7);
    write_match(7, 63, 63);

    // Vector walk: R2, R3, R4, R5, R6
    for (int i = 0; i < 8; i++) begin
      do_fetch("R2_R3_R4_R5_R6", TBL[i][15], TBL[i][14:8], TBL[i][7], TBL[i][6:0]);
    end

    // R7: bad index ignored, one-cycle error pulse
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; wr_index = 6'd8; wr_rom_addr = 6'd10; wr_target = 6'd0;
    @(negedge clk);
    wr_en = 1'b0;
    check("R7", "wr_err pulse", 64'(wr_err), 64'd1);
    @(negedge clk);
    check("R7", "wr_err cleared", 64'(wr_err), 64'd0);
    do_fetch("R7", 1'b1, 7'd10, 1'b0, 7'd10);

    // R8: overwrite entry 0 to a new target
    write_match(0, 5, 7);
    do_fetch("R8", 1'b1, 7'd5, 1'b1, 7'd71);

    // R10: back-pressure
    out_ready = 1'b0;
    do_fetch("R10", 1'b1, 7'd5, 1'b1, 7'd71);
    check("R10", "fetch_ready stalled", 64'(fetch_ready), 64'd0);
    fetch_valid = 1'b1; fetch_vec = 1'b1; fetch_addr = 7'd12;
    @(negedge clk);
    check("R10", "held out_data", 64'(out_data), 64'(ram_model[7]));
    check("R10", "held out_valid", 64'(out_valid), 64'd1);
    out_ready = 1'b1;
    #1;
    check("R10", "fetch_ready drain", 64'(fetch_ready), 64'd1);
    @(negedge clk);
    fetch_valid = 1'b0;
    check("R10", "next triad", 64'(out_data), 64'(rom_exp(12)));

    // R1: reset clears entries, RAM survives
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "out_valid after reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    do_fetch("R1", 1'b1, 7'd5, 1'b0, 7'd5);
    do_fetch("R1", 1'b1, 7'd71, 1'b0, 7'd71);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule